// File: doc/BRIEF.md
# Banked DRAM Column Strobe Router

This block fans a host's per-byte-lane column strobes out to several banks of expansion DRAM. Its output is one active-low strobe for each (bank, lane) pair. Two high address bits choose the bank. The choice is frozen for the length of each row cycle. While the row strobe is inactive, a video-fetch flag steers every access to the highest bank. Each outgoing strobe is also gated by a phase clock. A strobe releases as soon as that phase goes high, even if the host still holds its column strobe low.

All inputs are oversampled on a fast system clock, and every output is registered. Any change on an input therefore shows at the outputs exactly one clock later. Output index `bank*NUM_LANES + lane` carries the strobe for that bank and byte lane. With the defaults, bits 1:0 belong to bank 0 and bits 7:6 to bank 3. Row, column and phase signals are active low. The video flag is active high.

Top module: `dram_lane_strobe_router`

## Requirements
- R1: While `row_n` is high and `video_req` is low, the bank used is the value on `bank_addr`. Bank b drives outputs `strobe_n[2b+1:2b]`, with lane 0 on the even bit.
- R2: While `row_n` is low, changes on `bank_addr` have no effect. The bank in use at the last sample with `row_n` high stays in use.
- R3: While `row_n` is high and `video_req` is high, the top bank (bank 3) is selected, whatever `bank_addr` holds.
- R4: If `video_req` drops while `row_n` is low, bank 3 stays selected. Address control returns only once `row_n` is sampled high again.
- R5: An output strobe is low only when its lane's `col_n` bit and `phase_n` are both low. A high `phase_n` drives every output high.
- R6: With both `col_n` bits high, all outputs are high, whatever the phase.
- R7: When both `col_n` bits are low, both lanes of the selected bank go low together. When only one bit is low, only that lane goes low.
- R8: A low `rst_n` on a clock edge drives all outputs high and clears the held bank to 0. A row cycle that starts straight after reset uses bank 0.
- R9: At no time do strobes of more than one bank sit low.
- R10: Every output reflects the inputs sampled at the preceding rising clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the strobes |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 1 | Host row strobe, active low |
| col_n | input | NUM_LANES | Host column strobes per byte lane, active low |
| phase_n | input | 1 | Phase clock; a high level releases all strobes |
| video_req | input | 1 | Video fetch flag, active high |
| bank_addr | input | BANK_BITS | Address bits choosing the bank |
| strobe_n | output | NUM_BANKS*NUM_LANES | Per-bank, per-lane column strobes, active low |

## Verification
A held bank that is wrong shows up the next time a column strobe goes low. The low pair then appears in the wrong slot of `strobe_n`, one clock after the column strobe. This can be several cycles after the fault itself, because nothing is visible while `col_n` stays high. The bench therefore changes `bank_addr` and `video_req` in the middle of a row cycle and then pulses the column strobes before `row_n` rises. This is where a bank that leaks through, or a video override that is lost, becomes observable. A wrong phase gate or a wrong lane mapping is visible in the very next cycle.

// File: rtl/dls_pkg.sv
package dls_pkg;
  function automatic int strobe_index(input int bank, input int lane, input int lanes);
    return bank * lanes + lane;
  endfunction
endpackage

// File: rtl/dls_bank_hold.sv
module dls_bank_hold #(
  parameter int NUM_BANKS = 4,
  localparam int BW = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_n,
  input  logic          video_req,
  input  logic [BW-1:0] bank_addr,
  output logic [BW-1:0] sel_now
);
  localparam logic [BW-1:0] TOP_BANK = BW'(NUM_BANKS - 1);

  logic [BW-1:0] sel_q;

  // Open window while row strobe idles; frozen otherwise.
  always_comb begin
    if (row_n) sel_now = video_req ? TOP_BANK : bank_addr;
    else       sel_now = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_now;
  end

  // R2: the held bank does not move while the row strobe is low
  p_hold_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !row_n |=> $stable(sel_q));

  // R4: a video fetch seen in the open window keeps the top bank into the row cycle
  p_video_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_n && video_req) ##1 !row_n |-> sel_now == TOP_BANK);

  // R8: reset clears the held bank
  p_reset_zero_r8: assert property (@(posedge clk)
    !rst_n |=> sel_q == '0);
endmodule

// File: rtl/dls_lane_gate.sv
module dls_lane_gate
  import dls_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_LANES = 2,
  localparam int BW = $clog2(NUM_BANKS),
  localparam int NOUT = NUM_BANKS * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BW-1:0]        sel,
  input  logic [NUM_LANES-1:0] col_n,
  input  logic                 phase_n,
  output logic [NOUT-1:0]      strobe_n
);
  logic [NUM_BANKS-1:0] bank_low;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      localparam int IDX = strobe_index(b, l, NUM_LANES);
      always_ff @(posedge clk) begin
        if (!rst_n) strobe_n[IDX] <= 1'b1;
        else        strobe_n[IDX] <= !((sel == BW'(b)) && !col_n[l] && !phase_n);
      end
    end
    assign bank_low[b] = ~&strobe_n[b*NUM_LANES +: NUM_LANES];
  end

  // R9: at most one bank drives any strobe low
  p_one_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_low));

  // R5: a high phase releases everything on the next cycle
  p_phase_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_n |=> &strobe_n);

  // R6: idle column strobes keep all outputs high
  p_col_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    &col_n |=> &strobe_n);

  // R8: reset drives all outputs high
  p_reset_high_r8: assert property (@(posedge clk)
    !rst_n |=> &strobe_n);
endmodule

// File: rtl/dram_lane_strobe_router.sv
module dram_lane_strobe_router #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_LANES = 2,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int NOUT = NUM_BANKS * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 row_n,
  input  logic [NUM_LANES-1:0] col_n,
  input  logic                 phase_n,
  input  logic                 video_req,
  input  logic [BANK_BITS-1:0] bank_addr,
  output logic [NOUT-1:0]      strobe_n
);
  logic [BANK_BITS-1:0] sel_now;

  dls_bank_hold #(.NUM_BANKS(NUM_BANKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .video_req(video_req),
    .bank_addr(bank_addr), .sel_now(sel_now)
  );

  dls_lane_gate #(.NUM_BANKS(NUM_BANKS), .NUM_LANES(NUM_LANES)) u_gate (
    .clk(clk), .rst_n(rst_n), .sel(sel_now), .col_n(col_n),
    .phase_n(phase_n), .strobe_n(strobe_n)
  );

  // R10: a lane strobe can only be low if its column strobe was low one cycle earlier
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n[0] |-> $past(!col_n[0] && !phase_n));
endmodule

// File: tb/dram_lane_strobe_router_tb.sv
`timescale 1ns/1ps
module dram_lane_strobe_router_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic row_n = 1;
  logic [1:0] col_n = 2'b11;
  logic phase_n = 1;
  logic video_req = 0;
  logic [1:0] bank_addr = 0;
  logic [7:0] strobe_n;

  int tests = 0;
  int fails = 0;
  logic [1:0] ref_sel = 0;
  logic [7:0] q_exp[$];
  string q_tag[$];
  bit finished = 0;

  always #10 clk = ~clk;

  dram_lane_strobe_router u_dut (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .phase_n(phase_n), .video_req(video_req), .bank_addr(bank_addr),
    .strobe_n(strobe_n)
  );

  task automatic drive(input logic r, input logic [1:0] c, input logic ph,
                       input logic v, input logic [1:0] a, input string tag);
    logic [1:0] eff;
    logic [7:0] e;
    @(negedge clk);
    rst_n = 1; row_n = r; col_n = c; phase_n = ph; video_req = v; bank_addr = a;
    eff = r ? (v ? 2'd3 : a) : ref_sel;
    ref_sel = eff;
    e = 8'hFF;
    for (int l = 0; l < 2; l++)
      if (!ph && !c[l]) e[eff*2 + l] = 1'b0;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    ref_sel = 0;
    q_exp.push_back(8'hFF);
    q_tag.push_back("R8 reset");
  endtask

  // Monitor: sample mid-high phase, one edge after the driver pushed.
  always @(posedge clk) begin
    #5;
    if (q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      logic [3:0] bl;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      tests++;
      if (strobe_n !== e) begin
        fails++;
        $display("FAIL %s: strobe_n=%b expected=%b", t, strobe_n, e);
      end
      for (int b = 0; b < 4; b++) bl[b] = ~&strobe_n[b*2 +: 2];
      tests++;
      if (!$onehot0(bl)) begin
        fails++;
        $display("FAIL R9: bank_low=%b expected at most one bit set", bl);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    do_reset();
    // R8: row cycle straight after reset uses bank 0 though address says 2
    drive(0, 2'b00, 0, 0, 2'd2, "R8 start bank0");
    drive(1, 2'b11, 1, 0, 2'd2, "R6 idle");
    drive(1, 2'b10, 0, 0, 2'd2, "R1 R10 lane0 bank2");
    drive(0, 2'b00, 0, 0, 2'd1, "R2 R7 held bank2 both lanes");
    drive(0, 2'b00, 1, 0, 2'd1, "R5 phase release");
    drive(0, 2'b01, 0, 0, 2'd0, "R7 lane1 only");
    drive(0, 2'b11, 0, 0, 2'd0, "R6 col idle phase low");
    drive(1, 2'b11, 0, 1, 2'd1, "R3 video open window");
    drive(0, 2'b00, 0, 1, 2'd1, "R3 video top bank");
    drive(0, 2'b00, 0, 0, 2'd0, "R4 video dropped in row");
    drive(0, 2'b10, 0, 0, 2'd2, "R4 still top");
    drive(1, 2'b00, 0, 0, 2'd1, "R1 R10 return to address");
    drive(1, 2'b00, 0, 1, 2'd0, "R3 video with row high");
    for (int a = 0; a < 4; a++) begin
      drive(1, 2'b11, 1, 0, 2'(a), "R1 open");
      drive(0, 2'b00, 0, 0, 2'(3 - a), "R1 R2 sweep");
      drive(0, 2'b00, 1, 0, 2'(a), "R5 sweep release");
    end
    do_reset();
    drive(0, 2'b01, 0, 0, 2'd3, "R8 after second reset");
    drive(1, 2'b11, 1, 0, 2'd0, "R6 final idle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule